// File: doc/BRIEF.md
# Bit-Rate Down-Counter with Periodic Timer Mode

This block is the bit-rate timebase of a two-wire serial bus controller. A down-counter is loaded from a programmable reload value and counts one step per clock. Each time it reaches a count of one it reloads and emits a single-cycle pulse. While the serial bus function is enabled, that pulse is a baud tick that paces the bus engine.

When the bus function is disabled and the timer-interrupt enable is set, the same counter becomes a free-running periodic timer. The pulse then goes out on a separate interrupt output and never on the baud-tick line, so the bus engine sees no activity and none of its status is touched.

A reload value of zero selects the longest period, 2^CNT_W clocks. A new reload value is picked up only when the counter next reloads. Any change to either mode input restarts the count from the reload value. When both mode inputs are low, the counter sits at the reload value and produces nothing.

Top module: `i2c_brg_timer`

## Requirements
- R1: During reset and on the first cycles after it, while both mode inputs are low, `baudTick` and `timerIrq` are 0.
- R2: `timerIrq` pulses only while `busEnable` is 0 and `timerIrqEn` is 1.
- R3: With reload value R (1..2^CNT_W-1), the clock edge that first samples a new mode counts as edge 0. The active output is high for exactly one cycle after edges R, 2R, 3R, ….
- R4: A reload value of 0 gives a period of 2^CNT_W cycles (65536 with the default width).
- R5: While `busEnable` is 1, pulses appear on `baudTick` with the period of R3, whatever the state of `timerIrqEn`, and `timerIrq` stays 0.
- R6: In timer mode (`busEnable`=0, `timerIrqEn`=1), `baudTick` stays 0.
- R7: A change to `reloadVal` in the middle of a count does not alter the pulse that ends that count. The new value sets the length of the following periods.
- R8: A change to `busEnable` or `timerIrqEn` restarts the count from the reload value at the next edge. Neither output pulses on the cycle after that edge.
- R9: With `busEnable`=0 and `timerIrqEn`=0, neither output pulses.
- R10: With reload value 1, the active output is high on every cycle after edge 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reloadVal | input | CNT_W | Reload value; 0 means 2^CNT_W |
| busEnable | input | 1 | Serial bus function enable |
| timerIrqEn | input | 1 | Timer interrupt enable, honoured only while the bus is disabled |
| baudTick | output | 1 | One-cycle bit-rate tick to the bus engine |
| timerIrq | output | 1 | One-cycle periodic timer interrupt |

## Verification
A counter that loses or gains a step shows up at the ports as a pulse one or more cycles away from the expected multiple of R. It is visible at the very first terminal count after a restart, so every check compares each output on every cycle of its window. If the mode decode is wrong, the pulse lands on the wrong output, or on either output while idle, on the first period. A reload latched at the wrong moment moves the pulse that ends the current period. A missed restart shows up as a pulse on the cycle directly after a mode change.

// File: rtl/brg_pkg.sv
package brg_pkg;

  // Strobes from the control to the counter datapath
  typedef struct packed {
    logic load;   // restart the count from the reload value
    logic fire;   // terminal count reached: reload and pulse
  } brgStrobe_t;

  // {busEnable, timerIrqEn}
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_TIMER = 2'b01,
    MODE_BUS   = 2'b10,
    MODE_BUS_T = 2'b11
  } brgMode_t;

endpackage

// File: rtl/brg_datapath.sv
module brg_datapath
  import brg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] reloadVal,
  input  brgStrobe_t       strobe,
  output logic             cntIsOne
);

  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] MAX_COUNT = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CW-1:0] ONE = {{CNT_W{1'b0}}, 1'b1};

  logic [CW-1:0] cnt;
  logic [CW-1:0] effReload;

  // zero reload means the full 2^CNT_W span
  always_comb begin
    if (reloadVal == '0) effReload = MAX_COUNT;
    else                 effReload = {1'b0, reloadVal};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cnt <= '0;
    else if (strobe.load || strobe.fire) cnt <= effReload;
    else                                 cnt <= cnt - ONE;
  end

  assign cntIsOne = (cnt == ONE);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= MAX_COUNT);

  // R3
  count_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cnt != '0));

  // R7
  hold_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.fire && !$isunknown(cnt) && cnt != '0)
      |=> (cnt < $past(cnt)));

endmodule

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busEnable,
  input  logic       timerIrqEn,
  input  logic       cntIsOne,
  output brgStrobe_t strobe,
  output logic       baudTick,
  output logic       timerIrq
);

  brgMode_t curMode;
  brgMode_t prevMode;
  logic     modeChg;
  logic     active;

  assign curMode = brgMode_t'({busEnable, timerIrqEn});
  assign modeChg = (curMode != prevMode);
  assign active  = (curMode != MODE_IDLE);

  // idle keeps the counter parked on the reload value
  always_comb begin
    strobe.load = modeChg || !active;
    strobe.fire = active && !strobe.load && cntIsOne;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevMode <= MODE_IDLE;
      baudTick <= 1'b0;
      timerIrq <= 1'b0;
    end else begin
      prevMode <= curMode;
      baudTick <= strobe.fire && busEnable;
      timerIrq <= strobe.fire && !busEnable && timerIrqEn;
    end
  end

  // R2
  timer_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerIrq |-> $past(!busEnable && timerIrqEn));

  // R5
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> $past(busEnable));

  // R6
  out_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(baudTick && timerIrq));

  // R8
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> (!baudTick && !timerIrq));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(curMode == MODE_IDLE) |-> (!baudTick && !timerIrq));

endmodule

// File: rtl/i2c_brg_timer.sv
module i2c_brg_timer
  import brg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             busEnable,
  input  logic             timerIrqEn,
  output logic             baudTick,
  output logic             timerIrq
);

  brgStrobe_t strobe;
  logic       cntIsOne;

  brg_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .busEnable  (busEnable),
    .timerIrqEn (timerIrqEn),
    .cntIsOne   (cntIsOne),
    .strobe     (strobe),
    .baudTick   (baudTick),
    .timerIrq   (timerIrq)
  );

  brg_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .reloadVal (reloadVal),
    .strobe    (strobe),
    .cntIsOne  (cntIsOne)
  );

endmodule

// File: tb/i2c_brg_timer_tb.sv
module i2c_brg_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NVEC = 7;

  // {busEnable, timerIrqEn, reload[15:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 16'd5},
    {1'b0, 1'b1, 16'd2},
    {1'b1, 1'b0, 16'd7},
    {1'b1, 1'b0, 16'd3},
    {1'b1, 1'b1, 16'd4},
    {1'b0, 1'b0, 16'd3},
    {1'b0, 1'b1, 16'd13}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] reloadVal = '0;
  logic         busEnable = 1'b0;
  logic         timerIrqEn = 1'b0;
  logic         baudTick;
  logic         timerIrq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  i2c_brg_timer #(.CNT_W(W)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .reloadVal  (reloadVal),
    .busEnable  (busEnable),
    .timerIrqEn (timerIrqEn),
    .baudTick   (baudTick),
    .timerIrq   (timerIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected < 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic goIdle();
    busEnable  = 1'b0;
    timerIrqEn = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  // Apply a mode, then compare both outputs on every edge of the window.
  // Reports the number of mismatching cycles per output.
  task automatic runWindow(input string tag, input bit bus, input bit tmr,
                           input logic [W-1:0] rl, input int len);
    int period;
    int badB;
    int badI;
    bit expPulse;
    period = (rl == 0) ? (1 << W) : int'(rl);
    badB = 0;
    badI = 0;
    reloadVal  = rl;
    busEnable  = bus;
    timerIrqEn = tmr;
    @(posedge clk);   // edge 0: restart
    for (int k = 1; k <= len; k++) begin
      @(posedge clk);
      #1;
      expPulse = (k % period) == 0;
      if (baudTick !== (bus && expPulse)) badB++;
      if (timerIrq !== (!bus && tmr && expPulse)) badI++;
    end
    check({tag, " baudTick mismatching cycles"}, badB, 0);
    check({tag, " timerIrq mismatching cycles"}, badI, 0);
    goIdle();
  endtask

  initial begin
    // R1: reset state
    #1;
    check("R1 baudTick in reset", int'(baudTick), 0);
    check("R1 timerIrq in reset", int'(timerIrq), 0);
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 baudTick after reset", int'(baudTick), 0);
    check("R1 timerIrq after reset", int'(timerIrq), 0);

    // Table walk: R2 R3 R5 R6 R9
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      logic [W-1:0] rl;
      int per;
      rl  = VEC[v][15:0];
      per = (rl == 0) ? 65536 : int'(rl);
      if (VEC[v][17])      tag = "R3 R5 bus mode";
      else if (VEC[v][16]) tag = "R2 R3 R6 timer mode";
      else                 tag = "R9 idle";
      runWindow(tag, VEC[v][17], VEC[v][16], rl, 3 * per + 1);
    end

    // R10: reload of one pulses every cycle
    runWindow("R10 reload one timer", 1'b0, 1'b1, 16'd1, 6);
    runWindow("R10 reload one bus", 1'b1, 1'b0, 16'd1, 6);

    // R4: reload zero gives the full 65536-cycle period
    runWindow("R4 reload zero", 1'b0, 1'b1, 16'd0, 65537);

    // R7: reload change mid-count applies from the next reload
    begin
      int badI;
      bit exp;
      badI = 0;
      reloadVal  = 16'd10;
      timerIrqEn = 1'b1;
      @(posedge clk);
      for (int k = 1; k <= 19; k++) begin
        @(posedge clk);
        #1;
        exp = (k == 10) || (k == 14) || (k == 18);
        if (timerIrq !== exp) badI++;
        if (k == 3) reloadVal = 16'd4;
      end
      check("R7 reload applied at next reload", badI, 0);
      goIdle();
    end

    // R8: mode change mid-count restarts the count
    begin
      int badB;
      int badI;
      bit expB;
      badB = 0;
      badI = 0;
      reloadVal  = 16'd6;
      timerIrqEn = 1'b1;
      @(posedge clk);
      for (int k = 1; k <= 12; k++) begin
        @(posedge clk);
        #1;
        expB = (k == 11);
        if (baudTick !== expB) badB++;
        if (timerIrq !== 1'b0) badI++;
        if (k == 4) busEnable = 1'b1;
      end
      check("R8 baudTick after restart", badB, 0);
      check("R8 no timerIrq after restart", badI, 0);
      goIdle();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule